// File: doc/BRIEF.md
# Watchdog with Pre-Warning Pulse

This block watches a strobe line that software toggles while it is healthy. If the strobe stops changing for a whole timeout window, the block first drops an active-low warning pulse of fixed width. A few cycles later it lowers an active-low fault level. The fault level stays low until software toggles the strobe again. While no toggle arrives, the timer keeps re-arming, so a stalled program gets a fresh warning pulse at the end of every further window.

A select input chooses between a default and an alternative timeout length. A built-in latch records two timeouts in a row with no toggle between them; a separate rearm input clears it. The warning pulse can serve as a strobe for external shutdown logic, and the latch output can hold a system in reset. The active-low reset puts the whole block into its idle state. All timing is in clock cycles, set by parameters.

Top module: `wdog_prewarn`

## Requirements
- R1: While `rst_n` is low, `warn_n_o` and `fault_n_o` are high, `dbl_fault_o` is low and all counters are cleared. With the strobe held still after release, the first warning falls on rising edge TMO_DEF_CYC after release (64 with default parameters).
- R2: A level change on `strobe_i` made between two rising edges restarts the timeout on the third rising edge after the change, which is two synchronizer stages plus one. The next warning then falls exactly one timeout later.
- R3: When a timeout expires, `warn_n_o` goes low for exactly WARN_CYC cycles (6 by default).
- R4: `fault_n_o` falls LEAD_CYC cycles (2 by default) after the falling edge of `warn_n_o`. LEAD_CYC is at least 1 and below WARN_CYC.
- R5: Once low, `fault_n_o` stays low until a strobe change; it rises on the third rising edge after that change.
- R6: With no strobe change, timeouts repeat every timeout period, each one with a new warning pulse, counted from the start of the previous pulse.
- R7: `alt_sel_i` high selects TMO_ALT_CYC (24 by default) as the timeout length; low selects TMO_DEF_CYC.
- R8: If the selected timeout is shortened while the counter already stands at or beyond the new limit, the timeout expires on the next rising edge.
- R9: A strobe change that is registered during the lead interval cancels the pending fall of `fault_n_o`.
- R10: `dbl_fault_o` sets on the edge where a warning begins only if `fault_n_o` is already low at that edge. The first timeout after a strobe change never sets it.
- R11: `rearm_i` high at a rising edge clears `dbl_fault_o`, except when a set occurs on that same edge, in which case the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset; disables the watchdog |
| strobe_i | input | 1 | Software activity strobe, asynchronous to `clk` |
| alt_sel_i | input | 1 | 1 selects the alternative timeout, 0 the default |
| rearm_i | input | 1 | Clears the double-fault latch |
| warn_n_o | output | 1 | Active-low early-warning pulse |
| fault_n_o | output | 1 | Active-low fault level |
| dbl_fault_o | output | 1 | High after two consecutive timeouts |

## Verification
The bench places strobe changes one cycle on either side of the timeout boundary. A design that counts the synchronizer delay wrongly moves the warning by one cycle and misses these windows. It switches to the shorter timeout while the counter is already past the new limit; an equality compare would wrap around and skip the timeout entirely. It toggles the strobe so that the registered edge lands on the very cycle the fault level would fall, and it pulses rearm together with a second timeout. A wrong priority in either case leaves a fault low or drops a double-fault record.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

   // Width of a counter that must hold values 0..n (never below one bit).
   function automatic int cnt_w(input int n);
      int w;
      w = $clog2(n + 1);
      return (w < 1) ? 1 : w;
   endfunction

   localparam int SYNC_MIN = 1;

endpackage

// File: rtl/wdp_strobe_edge.sv
module wdp_strobe_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   output logic edge_o
);
   import wdp_pkg::*;

   if (SYNC_STAGES < SYNC_MIN) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= strobe_i;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[SYNC_STAGES-1];
   end

   // Any level change between consecutive synchronized samples.
   assign edge_o = sync_q[SYNC_STAGES-1] ^ last_q;

endmodule

// File: rtl/wdp_timer.sv
module wdp_timer #(
   parameter int TMO_DEF_CYC = 64,
   parameter int TMO_ALT_CYC = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic alt_sel_i,
   input  logic restart_i,
   output logic expire_o
);
   import wdp_pkg::*;

   localparam int TMO_MAX = (TMO_DEF_CYC > TMO_ALT_CYC) ? TMO_DEF_CYC : TMO_ALT_CYC;
   localparam int CW      = cnt_w(TMO_MAX);

   if (TMO_DEF_CYC < 2 || TMO_ALT_CYC < 2) begin : g_bad_tmo
      $error("timeouts must be at least 2 cycles");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim_last;

   if (TMO_DEF_CYC == TMO_ALT_CYC) begin : g_single
      logic unused_sel;
      assign unused_sel = alt_sel_i;
      assign lim_last   = CW'(TMO_DEF_CYC - 1);
   end else begin : g_dual
      assign lim_last = alt_sel_i ? CW'(TMO_ALT_CYC - 1) : CW'(TMO_DEF_CYC - 1);
   end

   // Magnitude compare so a shortened limit below the count still expires.
   assign expire_o = !restart_i && (cnt_q >= lim_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (restart_i || expire_o) cnt_q <= '0;
      else                            cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/wdp_warn_seq.sv
module wdp_warn_seq #(
   parameter int WARN_CYC = 6,
   parameter int LEAD_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire_i,
   input  logic strobe_edge_i,
   output logic warn_n_o,
   output logic fault_n_o
);
   import wdp_pkg::*;

   localparam int WW = cnt_w(WARN_CYC);
   localparam int LW = cnt_w(LEAD_CYC);

   if (LEAD_CYC < 1 || LEAD_CYC >= WARN_CYC) begin : g_bad_lead
      $error("need 1 <= LEAD_CYC < WARN_CYC");
   end

   logic [WW-1:0] wcnt_q;
   logic [LW-1:0] lcnt_q;

   // Warning pulse: WARN_CYC cycles low from each expiry.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warn_n_o <= 1'b1;
         wcnt_q   <= '0;
      end else if (expire_i) begin
         warn_n_o <= 1'b0;
         wcnt_q   <= WW'(WARN_CYC - 1);
      end else if (!warn_n_o) begin
         if (wcnt_q == '0) warn_n_o <= 1'b1;
         else              wcnt_q   <= wcnt_q - 1'b1;
      end
   end

   // Fault level: falls after the lead interval, rises on a strobe edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_n_o <= 1'b1;
         lcnt_q    <= '0;
      end else if (strobe_edge_i) begin
         fault_n_o <= 1'b1;
         lcnt_q    <= '0;
      end else if (expire_i) begin
         lcnt_q    <= LW'(LEAD_CYC);
      end else if (lcnt_q != '0) begin
         lcnt_q <= lcnt_q - 1'b1;
         if (lcnt_q == LW'(1)) fault_n_o <= 1'b0;
      end
   end

endmodule

// File: rtl/wdp_dbl_latch.sv
module wdp_dbl_latch #(
   parameter bit DBL_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire_i,
   input  logic fault_n_i,
   input  logic rearm_i,
   output logic dbl_o
);

   if (DBL_EN) begin : g_latch
      logic dbl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      dbl_q <= 1'b0;
         else if (expire_i && !fault_n_i) dbl_q <= 1'b1;
         else if (rearm_i)                dbl_q <= 1'b0;
      end
      assign dbl_o = dbl_q;
   end else begin : g_none
      logic unused_in;
      assign unused_in = ^{clk, rst_n, expire_i, fault_n_i, rearm_i};
      assign dbl_o     = 1'b0;
   end

endmodule

// File: rtl/wdog_prewarn.sv
module wdog_prewarn #(
   parameter int TMO_DEF_CYC = 64,
   parameter int TMO_ALT_CYC = 24,
   parameter int WARN_CYC    = 6,
   parameter int LEAD_CYC    = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit DBL_EN      = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   input  logic alt_sel_i,
   input  logic rearm_i,
   output logic warn_n_o,
   output logic fault_n_o,
   output logic dbl_fault_o
);

   localparam int TMO_MIN = (TMO_DEF_CYC < TMO_ALT_CYC) ? TMO_DEF_CYC : TMO_ALT_CYC;

   if (TMO_MIN <= WARN_CYC) begin : g_bad_window
      $error("timeouts must exceed WARN_CYC");
   end

   logic strobe_edge;
   logic tmo_expire;

   wdp_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (strobe_i),
      .edge_o   (strobe_edge)
   );

   wdp_timer #(.TMO_DEF_CYC(TMO_DEF_CYC), .TMO_ALT_CYC(TMO_ALT_CYC)) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .alt_sel_i (alt_sel_i),
      .restart_i (strobe_edge),
      .expire_o  (tmo_expire)
   );

   wdp_warn_seq #(.WARN_CYC(WARN_CYC), .LEAD_CYC(LEAD_CYC)) i_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .expire_i      (tmo_expire),
      .strobe_edge_i (strobe_edge),
      .warn_n_o      (warn_n_o),
      .fault_n_o     (fault_n_o)
   );

   wdp_dbl_latch #(.DBL_EN(DBL_EN)) i_dbl (
      .clk       (clk),
      .rst_n     (rst_n),
      .expire_i  (tmo_expire),
      .fault_n_i (fault_n_o),
      .rearm_i   (rearm_i),
      .dbl_o     (dbl_fault_o)
   );

endmodule

// File: rtl/wdog_prewarn_chk.sv
module wdog_prewarn_chk #(
   parameter int WARN_CYC = 6,
   parameter int LEAD_CYC = 2
) (
   input logic clk,
   input logic rst_n,
   input logic warn_n,
   input logic fault_n,
   input logic dbl_fault,
   input logic rearm,
   input logic strobe_edge,
   input logic tmo_expire
);

   localparam int RW = $clog2(WARN_CYC + 2);

   logic [RW-1:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   low_run <= '0;
      else if (warn_n)              low_run <= '0;
      else if (low_run != {RW{1'b1}}) low_run <= low_run + 1'b1;
   end

   // R3
   warn_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(warn_n) |-> (low_run == RW'(WARN_CYC)));

   // R4
   fault_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_n) |-> (low_run == RW'(LEAD_CYC)));

   // R5
   fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_n) |-> $past(strobe_edge));

   // R6
   warn_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(warn_n) |-> $past(tmo_expire));

   // R10
   dbl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dbl_fault) |-> ($fell(warn_n) && !$past(fault_n)));

   // R11
   rearm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rearm && !tmo_expire) |=> !dbl_fault);

endmodule

bind wdog_prewarn wdog_prewarn_chk #(.WARN_CYC(WARN_CYC), .LEAD_CYC(LEAD_CYC)) i_wdog_prewarn_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .warn_n      (warn_n_o),
   .fault_n     (fault_n_o),
   .dbl_fault   (dbl_fault_o),
   .rearm       (rearm_i),
   .strobe_edge (strobe_edge),
   .tmo_expire  (tmo_expire)
);

// File: tb/test_wdog_prewarn.sv
module test_wdog_prewarn;

   localparam int T_DEF = 64;
   localparam int T_ALT = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic strobe = 1'b0;
   logic alt_sel = 1'b0;
   logic rearm = 1'b0;
   logic warn_n, fault_n, dbl;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wdog_prewarn #(.TMO_DEF_CYC(T_DEF), .TMO_ALT_CYC(T_ALT), .WARN_CYC(6), .LEAD_CYC(2)) i_wdog_prewarn (
      .clk         (clk),
      .rst_n       (rst_n),
      .strobe_i    (strobe),
      .alt_sel_i   (alt_sel),
      .rearm_i     (rearm),
      .warn_n_o    (warn_n),
      .fault_n_o   (fault_n),
      .dbl_fault_o (dbl)
   );

   // {alt, gap cycles after the strobe change, warning falls seen, fault level at end}
   localparam logic [31:0] VECS [0:8] = '{
      {1'b0, 15'd40,  8'd0, 8'd1},   // R2 well inside the window
      {1'b0, 15'd66,  8'd0, 8'd1},   // R2 one cycle before expiry
      {1'b0, 15'd67,  8'd1, 8'd1},   // R2/R3 expiry on the last cycle
      {1'b0, 15'd69,  8'd1, 8'd0},   // R4 fault just fallen
      {1'b1, 15'd20,  8'd0, 8'd1},   // R7 short window, no expiry
      {1'b1, 15'd27,  8'd1, 8'd1},   // R7 expiry on the last cycle
      {1'b1, 15'd29,  8'd1, 8'd0},   // R7/R4 fault at the last cycle
      {1'b1, 15'd60,  8'd2, 8'd0},   // R6 repeated short timeouts
      {1'b0, 15'd200, 8'd3, 8'd0}    // R6 repeated default timeouts
   };

   task automatic step();
      @(negedge clk);
      cyc++;
   endtask

   task automatic wait_to(input int n);
      while (cyc < n) step();
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      strobe  = 1'b0;
      alt_sel = 1'b0;
      rearm   = 1'b0;
      rst_n   = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc   = 0;
   endtask

   initial begin
      #2 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 warn in reset", int'(warn_n), 1);
      chk("R1 fault in reset", int'(fault_n), 1);
      chk("R1 dbl in reset", int'(dbl), 0);
      rst_n = 1'b1;
      cyc = 0;

      // Table walk
      for (int v = 0; v < 9; v++) begin
         logic prev;
         int   falls;
         int   gap;
         // settle: restart the counter, unchecked
         alt_sel = VECS[v][31];
         strobe  = ~strobe;
         repeat (3) step();
         gap    = int'(VECS[v][30:16]);
         falls  = 0;
         prev   = warn_n;
         strobe = ~strobe;
         for (int i = 0; i < gap; i++) begin
            step();
            if (prev && !warn_n) falls++;
            prev = warn_n;
         end
         chk($sformatf("R2/R7 vector %0d warning count", v), falls, int'(VECS[v][15:8]));
         chk($sformatf("R4/R5 vector %0d fault level", v), int'(fault_n), int'(VECS[v][7:0]));
      end

      // Directed tests
      do_reset();
      wait_to(63);  chk("R1 no warning before timeout", int'(warn_n), 1);
      wait_to(64);  chk("R1 first warning at timeout", int'(warn_n), 0);
      wait_to(65);  chk("R4 fault still high in lead", int'(fault_n), 1);
      wait_to(66);  chk("R4 fault falls after lead", int'(fault_n), 0);
                    chk("R10 first timeout leaves latch clear", int'(dbl), 0);
      wait_to(69);  chk("R3 warning still low", int'(warn_n), 0);
      wait_to(70);  chk("R3 warning width", int'(warn_n), 1);
      wait_to(127); chk("R6 no early second warning", int'(warn_n), 1);
      wait_to(128); chk("R6 second warning", int'(warn_n), 0);
                    chk("R10 double fault set", int'(dbl), 1);
                    chk("R5 fault held low", int'(fault_n), 0);
      wait_to(130); strobe = 1'b1;
      wait_to(132); chk("R5 fault low before edge lands", int'(fault_n), 0);
      wait_to(133); chk("R5 fault released by strobe", int'(fault_n), 1);
                    chk("R11 latch holds without rearm", int'(dbl), 1);
      wait_to(134); rearm = 1'b1;
      step();       rearm = 1'b0;
                    chk("R11 rearm clears latch", int'(dbl), 0);
      wait_to(196); chk("R2 restart moved expiry", int'(warn_n), 1);
                    strobe = 1'b0;
      wait_to(197); chk("R2 warning one timeout after restart", int'(warn_n), 0);
                    chk("R10 no set with fault high", int'(dbl), 0);
      wait_to(198); chk("R9 fault high in lead", int'(fault_n), 1);
      wait_to(199); chk("R9 edge cancels fault fall", int'(fault_n), 1);
      wait_to(200); chk("R9 fault stays high", int'(fault_n), 1);
      wait_to(240); chk("R8 no warning before switch", int'(warn_n), 1);
                    alt_sel = 1'b1;
      wait_to(241); chk("R8 shortened limit expires at once", int'(warn_n), 0);
      wait_to(243); chk("R4 fault after shortened expiry", int'(fault_n), 0);
      wait_to(264); chk("R7 no early alt warning", int'(warn_n), 1);
      wait_to(265); chk("R7 alternative timeout length", int'(warn_n), 0);
                    chk("R10 second timeout sets latch", int'(dbl), 1);
      wait_to(284); rearm = 1'b1;
      step();       chk("R11 rearm clears latch again", int'(dbl), 0);
      wait_to(288);
      step();       rearm = 1'b0;
                    chk("R11 set wins over rearm", int'(dbl), 1);
      rst_n = 1'b0;
      step();
      chk("R1 reset forces warning high", int'(warn_n), 1);
      chk("R1 reset forces fault high", int'(fault_n), 1);
      chk("R1 reset clears latch", int'(dbl), 0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule